// File: doc/BRIEF.md
# Dual-Clock Parity FIFO with Programmable Threshold Flags

This block is a 64-word, 36-bit first-in first-out buffer between two independent clock domains. The producer writes on the rising edge of the write clock when its write enable is high. The consumer reads on the rising edge of the read clock when its read enable is high. The two clocks may be unrelated or may be the same net. Both pointers carry one extra wrap bit, and each pointer is Gray-coded before a two-flop synchronizer brings it into the other domain. Full and almost-full are therefore computed in the write domain, and empty and almost-empty in the read domain.

Each flag side is a small state machine. The write side has three states. In W_OPEN the free space is above the almost-full offset. In W_TIGHT the free space is at or below that offset but not zero. In W_FULL all 64 words are in use. The read side also has three states. In R_EMPTY no words are stored. In R_LOW the stored count is at or below the almost-empty offset. In R_AVAIL the count is above that offset. On each clock a side moves directly to whichever of its states matches the count it will hold after that edge, so every transition between two states of a side is legal. Reset enters W_OPEN and R_EMPTY.

A word is four 9-bit lanes. Bits 9i+7..9i are data and bit 9i+8 is that lane's odd-parity bit. Incoming words are checked and stored unchanged. On the read side the stored parity bits can be replaced with freshly computed ones.

Top module: `xclk_fifo`

## Requirements
- R1: While rst_n is low and after its release with no traffic: empty=1, almost_empty=1, full=0, almost_full=0, par_err=0.
- R2: Words leave the read port in the order they were accepted, bit for bit, including parity bits when regen_par=0. rd_data updates one read-clock edge after an accepted read (rd_en=1 and empty=0).
- R3: full is 1 exactly when 64 words are stored (once the synchronized read pointer is current). A write while full is ignored: no word is stored and the pointer does not move.
- R4: empty is 1 exactly when no word is stored (once the synchronized write pointer is current). A read while empty is ignored: rd_data holds its value and the pointer does not move.
- R5: almost_full is 1 when the free space (64 minus stored count) is less than or equal to the value on af_offset captured while rst_n was low. Changes to af_offset after reset have no effect.
- R6: almost_empty is 1 when the stored count is less than or equal to the value on ae_offset captured while rst_n was low. Later changes to ae_offset have no effect.
- R7: par_err is high for one write-clock cycle after an edge that sampled wr_en=1 with any lane whose 9 bits have an even number of ones. Otherwise it is 0. It does not depend on full.
- R8: With regen_par=1, bit 9i+8 of rd_data is the odd parity of rd_data[9i+7:9i] for each lane. With regen_par=0 the stored bits are shown. The select acts on the current output without a new read.
- R9: Each pointer's Gray code changes by at most one bit per clock of its own domain. Data integrity holds across many pointer wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the offset capture window |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to write, four lanes of 8 data plus odd parity |
| af_offset | input | 6 | Almost-full offset, captured during reset |
| full | output | 1 | No free space (write domain) |
| almost_full | output | 1 | Free space at or below offset (write domain) |
| par_err | output | 1 | Parity fault seen on the last write-edge sample |
| rclk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read request |
| regen_par | input | 1 | 1 = recompute parity bits on rd_data |
| ae_offset | input | 6 | Almost-empty offset, captured during reset |
| rd_data | output | 36 | Last word read |
| empty | output | 1 | No stored word (read domain) |
| almost_empty | output | 1 | Stored count at or below offset (read domain) |

## Verification
The embedded properties check on every clock that a write while full and a read while empty leave the pointers untouched. They also check that the count seen from either side never exceeds the depth, and that each Gray pointer changes by at most one bit per step. Properties cannot show the flag thresholds, the offsets being captured only during reset, data order, parity fault detection or the parity regeneration select. The bench scenarios show these: directed fills and drains across both thresholds, a corrupted-lane word read back both ways, and a long random run against a queue model with the two clocks at unrelated rates.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
    localparam int LANE_DATA_W = 8;
    localparam int LANE_W      = LANE_DATA_W + 1;

    typedef enum logic [1:0] {W_OPEN, W_TIGHT, W_FULL}  wr_state_t;
    typedef enum logic [1:0] {R_EMPTY, R_LOW, R_AVAIL}  rd_state_t;

    function automatic logic odd_bit(input logic [LANE_DATA_W-1:0] b);
        return ~(^b);
    endfunction
endpackage

// File: rtl/gray_sync.sv
`timescale 1ns/1ps
module gray_sync #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] d_gray,
    output logic [PW-1:0] q_gray
);
    logic [PW-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_gray <= '0;
        end else begin
            stage1 <= d_gray;
            q_gray <= stage1;
        end
    end
endmodule

// File: rtl/xfifo_wr_side.sv
`timescale 1ns/1ps
module xfifo_wr_side
    import xfifo_pkg::*;
#(
    parameter int AW = 6,
    parameter int W  = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] af_off,
    input  logic [AW:0]   rgray_sync,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          mem_we,
    output logic          full,
    output logic          almost_full,
    output logic          par_err
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int LANES = W / LANE_W;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    wr_state_t     st, st_nxt;
    logic [PW-1:0] wbin, wbin_nxt, rbin_seen, used_nxt, free_nxt;
    logic [AW-1:0] thr;
    logic          push;
    logic [LANES-1:0] lane_bad;

    assign push      = wr_en && !full;
    assign mem_we    = push;
    assign waddr     = wbin[AW-1:0];
    assign wbin_nxt  = wbin + PW'(push);
    assign rbin_seen = g2b(rgray_sync);
    assign used_nxt  = wbin_nxt - rbin_seen;
    assign free_nxt  = PW'(DEPTH) - used_nxt;

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        assign lane_bad[i] = ~(^wr_data[i*LANE_W +: LANE_W]);
    end

    always_comb begin
        if (used_nxt == PW'(DEPTH))      st_nxt = W_FULL;
        else if (free_nxt <= {1'b0, thr}) st_nxt = W_TIGHT;
        else                              st_nxt = W_OPEN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= W_OPEN;
        else        st <= st_nxt;
    end

    always_comb begin
        unique case (st)
            W_OPEN:  begin full = 1'b0; almost_full = 1'b0; end
            W_TIGHT: begin full = 1'b0; almost_full = 1'b1; end
            W_FULL:  begin full = 1'b1; almost_full = 1'b1; end
            default: begin full = 1'b0; almost_full = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            thr     <= af_off;
            par_err <= 1'b0;
        end else begin
            wbin    <= wbin_nxt;
            wgray   <= wbin_nxt ^ (wbin_nxt >> 1);
            par_err <= wr_en && (|lane_bad);
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(wbin));
    a_r3_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (PW'(wbin - rbin_seen) <= PW'(DEPTH)));
    a_r9_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wgray ^ $past(wgray)) <= 1));
endmodule

// File: rtl/xfifo_rd_side.sv
`timescale 1ns/1ps
module xfifo_rd_side
    import xfifo_pkg::*;
#(
    parameter int AW = 6,
    parameter int W  = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          regen,
    input  logic [AW-1:0] ae_off,
    input  logic [AW:0]   wgray_sync,
    input  logic [W-1:0]  mem_q,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic [W-1:0]  rd_data,
    output logic          empty,
    output logic          almost_empty
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int LANES = W / LANE_W;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    rd_state_t     st, st_nxt;
    logic [PW-1:0] rbin, rbin_nxt, wbin_seen, avail_nxt;
    logic [AW-1:0] thr;
    logic [W-1:0]  q_reg;
    logic          pop;

    assign pop       = rd_en && !empty;
    assign raddr     = rbin[AW-1:0];
    assign rbin_nxt  = rbin + PW'(pop);
    assign wbin_seen = g2b(wgray_sync);
    assign avail_nxt = wbin_seen - rbin_nxt;

    always_comb begin
        if (avail_nxt == '0)               st_nxt = R_EMPTY;
        else if (avail_nxt <= {1'b0, thr}) st_nxt = R_LOW;
        else                               st_nxt = R_AVAIL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= R_EMPTY;
        else        st <= st_nxt;
    end

    always_comb begin
        unique case (st)
            R_EMPTY: begin empty = 1'b1; almost_empty = 1'b1; end
            R_LOW:   begin empty = 1'b0; almost_empty = 1'b1; end
            R_AVAIL: begin empty = 1'b0; almost_empty = 1'b0; end
            default: begin empty = 1'b1; almost_empty = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            thr   <= ae_off;
            q_reg <= '0;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
            if (pop) q_reg <= mem_q;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_out
        assign rd_data[i*LANE_W +: LANE_DATA_W] = q_reg[i*LANE_W +: LANE_DATA_W];
        assign rd_data[i*LANE_W + LANE_DATA_W]  = regen
            ? odd_bit(q_reg[i*LANE_W +: LANE_DATA_W])
            : q_reg[i*LANE_W + LANE_DATA_W];
    end

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> ($stable(rbin) && $stable(q_reg)));
    a_r4_avail_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (PW'(wbin_seen - rbin) <= PW'(DEPTH)));
    a_r9_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
    parameter int AW = 6,
    parameter int W  = 36
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] af_offset,
    output logic          full,
    output logic          almost_full,
    output logic          par_err,
    input  logic          rclk,
    input  logic          rd_en,
    input  logic          regen_par,
    input  logic [AW-1:0] ae_offset,
    output logic [W-1:0]  rd_data,
    output logic          empty,
    output logic          almost_empty
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wgray, rgray, wgray_r, rgray_w;
    logic [AW-1:0] waddr, raddr;
    logic          mem_we;

    xfifo_wr_side #(.AW(AW), .W(W)) u_wr (
        .clk(wclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .af_off(af_offset), .rgray_sync(rgray_w), .wgray(wgray),
        .waddr(waddr), .mem_we(mem_we), .full(full),
        .almost_full(almost_full), .par_err(par_err)
    );

    gray_sync #(.PW(PW)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d_gray(rgray), .q_gray(rgray_w)
    );

    gray_sync #(.PW(PW)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d_gray(wgray), .q_gray(wgray_r)
    );

    always_ff @(posedge wclk) begin
        if (mem_we) mem[waddr] <= wr_data;
    end

    xfifo_rd_side #(.AW(AW), .W(W)) u_rd (
        .clk(rclk), .rst_n(rst_n), .rd_en(rd_en), .regen(regen_par),
        .ae_off(ae_offset), .wgray_sync(wgray_r), .mem_q(mem[raddr]),
        .rgray(rgray), .raddr(raddr), .rd_data(rd_data),
        .empty(empty), .almost_empty(almost_empty)
    );
endmodule

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
    logic        wclk = 0, rclk = 0, rst_n = 0;
    logic        wr_en = 0, rd_en = 0, regen_par = 0;
    logic [35:0] wr_data = '0;
    logic [5:0]  af_offset = 6'd10, ae_offset = 6'd5;
    logic        full, almost_full, par_err, empty, almost_empty;
    logic [35:0] rd_data;

    int n_chk = 0, n_fail = 0;
    int stored = 0;
    logic [35:0] q[$];
    bit done = 0;

    always #10 wclk = ~wclk;
    always #7  rclk = ~rclk;

    xclk_fifo u_xclk_fifo (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .af_offset(af_offset), .full(full), .almost_full(almost_full),
        .par_err(par_err), .rclk(rclk), .rd_en(rd_en), .regen_par(regen_par),
        .ae_offset(ae_offset), .rd_data(rd_data), .empty(empty),
        .almost_empty(almost_empty)
    );

    function automatic logic [35:0] fix_par(input logic [35:0] w);
        logic [35:0] r = w;
        for (int i = 0; i < 4; i++) r[i*9+8] = ~(^w[i*9 +: 8]);
        return r;
    endfunction

    function automatic logic [35:0] rnd_word();
        return fix_par({$urandom(), 4'($urandom())});
    endfunction

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic write_word(input logic [35:0] w, output bit acc, output logic pe);
        @(negedge wclk);
        acc = !full;
        wr_en = 1; wr_data = w;
        if (acc) q.push_back(w);
        @(negedge wclk);
        wr_en = 0;
        pe = par_err;
    endtask

    task automatic read_word(output bit acc, output logic [35:0] d);
        @(negedge rclk);
        acc = !empty;
        rd_en = 1;
        @(negedge rclk);
        rd_en = 0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (6) @(negedge wclk);
        repeat (6) @(negedge rclk);
    endtask

    task automatic flag_chk(input string tag);
        settle();
        chk(full == (stored == 64), {tag, " R3 full"}, 36'(full), 36'(stored == 64));
        chk(empty == (stored == 0), {tag, " R4 empty"}, 36'(empty), 36'(stored == 0));
        chk(almost_full == (64 - stored <= 10), {tag, " R5 almost_full"}, 36'(almost_full), 36'(64 - stored <= 10));
        chk(almost_empty == (stored <= 5), {tag, " R6 almost_empty"}, 36'(almost_empty), 36'(stored <= 5));
    endtask

    task automatic fill_to(input int n);
        bit a; logic pe;
        while (stored < n) begin
            write_word(rnd_word(), a, pe);
            if (a) stored++;
        end
    endtask

    task automatic drain_to(input int n);
        bit a; logic [35:0] d, e;
        while (stored > n) begin
            read_word(a, d);
            e = q.pop_front();
            chk(a && d == e, "R2 directed order", d, e);
            stored--;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 36'd0, 36'd1);
        finish_up();
    end

    initial begin
        bit a; logic pe; logic [35:0] d, e, bad, last;
        void'($urandom(32'd4242));
        #5;
        chk(empty && almost_empty && !full && !almost_full, "R1 in reset",
            {32'd0, empty, almost_empty, full, almost_full}, 36'b1100);
        #98 rst_n = 1;
        #20 af_offset = 6'd40; ae_offset = 6'd40;
        @(negedge wclk);
        chk(empty && almost_empty && !full && !almost_full && !par_err, "R1 after release",
            {31'd0, empty, almost_empty, full, almost_full, par_err}, 36'b11000);

        flag_chk("n=0");
        fill_to(5);  flag_chk("n=5");
        fill_to(6);  flag_chk("n=6");
        fill_to(53); flag_chk("n=53");
        fill_to(54); flag_chk("n=54");
        fill_to(64); flag_chk("n=64");
        for (int i = 0; i < 6; i++) begin
            write_word(36'hF_0000_0000 | 36'(i), a, pe);
            chk(!a, "R3 write while full refused", 36'(a), 36'd0);
        end
        flag_chk("n=64 after overflow tries");
        drain_to(6);  flag_chk("n=6 drain");
        drain_to(5);  flag_chk("n=5 drain");
        drain_to(0);  flag_chk("n=0 drain (R3 extra words absent)");

        last = rd_data;
        read_word(a, d);
        chk(!a && d == last, "R4 read while empty holds rd_data", d, last);
        flag_chk("n=0 after underflow try");
        e = rnd_word();
        write_word(e, a, pe); stored++;
        chk(pe == 1'b0, "R7 clean word", 36'(pe), 36'd0);
        settle();
        read_word(a, d); void'(q.pop_front()); stored--;
        chk(a && d == e, "R4 pointer unmoved by empty read", d, e);

        bad = rnd_word() ^ (36'd1 << 26);
        write_word(bad, a, pe); stored++;
        chk(pe == 1'b1, "R7 lane2 parity fault", 36'(pe), 36'd1);
        @(negedge wclk);
        chk(par_err == 1'b0, "R7 par_err drops when idle", 36'(par_err), 36'd0);
        write_word(fix_par(36'hA_5A5A_5A5A) ^ 36'h1, a, pe);
        chk(pe == 1'b1, "R7 lane0 fault", 36'(pe), 36'd1);
        settle();
        regen_par = 0;
        read_word(a, d); void'(q.pop_front()); stored--;
        chk(d == bad, "R2 R8 stored parity kept", d, bad);
        regen_par = 1; #1;
        chk(rd_data == fix_par(bad), "R8 regenerated parity", rd_data, fix_par(bad));
        read_word(a, d); void'(q.pop_front()); stored--;
        chk(d == fix_par(36'hA_5A5A_5A5A ^ 36'h1), "R8 regen lane0", d, fix_par(36'hA_5A5A_5A5A ^ 36'h1));
        regen_par = 0;

        fork
            begin
                for (int c = 0; c < 4000; c++) begin
                    @(negedge wclk);
                    wr_en = (c < 2000) ? ($urandom() % 4 != 0) : ($urandom() % 4 == 0);
                    wr_data = rnd_word();
                    if (wr_en && !full) q.push_back(wr_data);
                end
                @(negedge wclk);
                wr_en = 0;
            end
            begin
                bit pend = 0;
                logic [35:0] exp_w = '0;
                for (int c = 0; c < 9000; c++) begin
                    @(negedge rclk);
                    if (pend) begin
                        chk(rd_data == exp_w, "R2 R9 random order", rd_data, exp_w);
                        pend = 0;
                    end
                    rd_en = (c < 3000) ? ($urandom() % 3 == 0) : ($urandom() % 3 != 0);
                    if (rd_en && !empty) begin
                        pend = 1;
                        exp_w = q.pop_front();
                    end
                end
                @(negedge rclk);
                if (pend) chk(rd_data == exp_w, "R2 R9 random order", rd_data, exp_w);
                rd_en = 0;
            end
        join
        settle();
        chk(empty == (q.size() == 0), "R4 final empty", 36'(empty), 36'(q.size() == 0));
        finish_up();
    end
endmodule